// File: doc/BRIEF.md
# Card Clock Generator

This block derives the clock delivered to an inserted smart card from a reference clock. A select code picks one of four rates: the reference divided by eight, four or two, or the reference itself. The rate can change at any time without producing short pulses on the card clock. A separate stop control halts the card clock and parks it at a chosen high or low level. Releasing the stop resumes clocking at the selected rate, starting from the parked level.

The select, stop and park-level inputs normally come from a host register. They may be asynchronous to the reference, so they pass through a configurable chain of synchronizing flops (`SYNC_STAGES`, 0 removes it). The divided rates come from a counter-driven flop. The undivided rate comes from an AND-OR clock mux. Its enable is updated only while the reference is low.

Top module: `card_clk_gen`

## Requirements
- R1: The select code chooses the card clock period. Code 0 (binary 00) gives 8 reference periods, code 1 (01) gives 4, code 2 (10) gives 2 and code 3 (11) passes the reference through. Each rate has a 50 % duty cycle.
- R2: After reset the select state is code 0, so the card clock runs at the reference divided by 8 until a new code is synchronized.
- R3: While `rst_n` is low, the card clock is held low whatever the other inputs do, and the divider counter is cleared.
- R4: With `stop_req` high and `stop_high` low, the card clock stops and stays low for as long as `stop_req` stays high. A select change during that time does not disturb it.
- R5: With `stop_req` high and `stop_high` high, the card clock stops and stays high.
- R6: A stop takes effect at the next transition of the card clock into the park level. No pulse before the park is shorter than a half-period of the running rate.
- R7: Clearing `stop_req` restarts clocking from the parked level. The first half-period starts at the parked level, and the clock then runs at the select code in force at the first low point after the release.
- R8: A new select code among the divided rates takes effect only at a point where the card clock is low, and the divider counter restarts there. No pulse is ever shorter than the shorter half-period of the old and new rates.
- R9: Switching into or out of pass-through (code 3), and stopping or resuming in pass-through, produces no pulse shorter than the shorter half-period of the rates involved. The mux enable and the divided output are never both active at a reference rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | SEL_W | Rate select code (2 bits by default) |
| stop_req | input | 1 | High requests that the card clock be halted |
| stop_high | input | 1 | Park level while halted: 1 high, 0 low |
| card_clk | output | 1 | Clock delivered to the card |

## Verification
The hardest case to reach from the ports is a rate or stop request that lands at an awkward phase of the running divider. Examples are a switch out of pass-through just after a reference rise, or a park-high request while the card clock follows the reference directly. The bench sweeps every ordered pair of rates and every rate with both park levels, placing each request at two offsets within the reference period. A monitor times every card clock edge and keeps the narrowest pulse seen in each window. That minimum is compared against the bound computed in the bench from the rates involved.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;
   // Half-period, in reference cycles, of a divided rate. The code with all ones
   // is pass-through; it is reported as 1 so callers never see a zero length.
   function automatic int half_ref_cycles(input int code, input int sel_w);
      int sh;
      sh = (1 << sel_w) - 2 - code;
      if (sh < 0) return 1;
      return 1 << sh;
   endfunction
endpackage

// File: rtl/ccg_sync.sv
`timescale 1ns/1ps
module ccg_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk_ref,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("ccg_sync: W must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("ccg_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk_ref or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
         end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
         end
      end
      assign q_o = stage_q[STAGES-1];
   end
endmodule

// File: rtl/ccg_rate_ctrl.sv
`timescale 1ns/1ps
module ccg_rate_ctrl
   import ccg_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             halt_i,
   input  logic             park_hi_i,
   output logic             div_q_o,
   output logic             pass_req_o
);
   localparam int NSEL = 1 << SEL_W;
   localparam int CNT_W = NSEL - 2;
   localparam logic [SEL_W-1:0] FAST_CODE = {SEL_W{1'b1}};

   if (SEL_W < 2 || SEL_W > 3) begin : g_bad_sel
      $error("ccg_rate_ctrl: SEL_W must be 2 or 3");
   end

   logic [SEL_W-1:0] cur_sel;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_last;
   logic             div_q;
   logic             stopped;
   logic             edge_now;

   always_comb begin
      cnt_last = CNT_W'(half_ref_cycles(int'(cur_sel), SEL_W) - 1);
      edge_now = (cnt == cnt_last);
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         cur_sel <= '0;
         cnt     <= '0;
         div_q   <= 1'b0;
         stopped <= 1'b0;
      end else if (stopped) begin
         if (!halt_i) begin
            stopped <= 1'b0;
            cnt     <= '0;
            if (!div_q)                  cur_sel <= sel_i;
            else if (cur_sel == FAST_CODE) div_q <= 1'b0;
         end
      end else if (cur_sel == FAST_CODE) begin
         if (halt_i) begin
            stopped <= 1'b1;
            div_q   <= park_hi_i;
         end else if (sel_i != FAST_CODE) begin
            cur_sel <= sel_i;
            cnt     <= '0;
         end
      end else if (edge_now) begin
         cnt   <= '0;
         div_q <= ~div_q;
         if (div_q) begin
            cur_sel <= sel_i;
            if (halt_i && !park_hi_i) stopped <= 1'b1;
         end else if (halt_i && park_hi_i) begin
            stopped <= 1'b1;
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign div_q_o    = div_q;
   assign pass_req_o = (cur_sel == FAST_CODE) && !stopped;

   // R8
   rate_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !$stable(cur_sel) |-> !div_q);
   // R8
   cnt_range_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!stopped && cur_sel != FAST_CODE) |-> (cnt <= cnt_last));
   // R5
   park_level_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(stopped) |-> (div_q == $past(park_hi_i)));
   // R4
   stop_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (stopped && $past(stopped)) |-> $stable(div_q));
   // R9
   fast_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      pass_req_o |-> !div_q);
endmodule

// File: rtl/ccg_bypass_gate.sv
`timescale 1ns/1ps
module ccg_bypass_gate (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic pass_req_i,
   input  logic div_q_i,
   output logic card_clk_o
);
   logic pass_en;

   // Enable moves only on the falling reference edge, while the AND input is low.
   always_ff @(negedge clk_ref or negedge rst_n) begin
      if (!rst_n) pass_en <= 1'b0;
      else        pass_en <= pass_req_i;
   end

   assign card_clk_o = div_q_i | (clk_ref & pass_en);

   // R9
   mux_excl_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      pass_en |-> !div_q_i);
endmodule

// File: rtl/card_clk_gen.sv
`timescale 1ns/1ps
module card_clk_gen #(
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] rate_sel,
   input  logic             stop_req,
   input  logic             stop_high,
   output logic             card_clk
);
   localparam int CTL_W = SEL_W + 2;

   logic [CTL_W-1:0] ctl_raw;
   logic [CTL_W-1:0] ctl_s;
   logic             div_q;
   logic             pass_req;

   assign ctl_raw = {rate_sel, stop_req, stop_high};

   ccg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .d_i     (ctl_raw),
      .q_o     (ctl_s)
   );

   ccg_rate_ctrl #(.SEL_W(SEL_W)) u_rate (
      .clk_ref    (clk_ref),
      .rst_n      (rst_n),
      .sel_i      (ctl_s[CTL_W-1:2]),
      .halt_i     (ctl_s[1]),
      .park_hi_i  (ctl_s[0]),
      .div_q_o    (div_q),
      .pass_req_o (pass_req)
   );

   ccg_bypass_gate u_gate (
      .clk_ref    (clk_ref),
      .rst_n      (rst_n),
      .pass_req_i (pass_req),
      .div_q_i    (div_q),
      .card_clk_o (card_clk)
   );
endmodule

// File: tb/card_clk_gen_bench.sv
`timescale 1ns/1ps
module card_clk_gen_bench;
   logic       clk_ref = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic       stop_req = 1'b0;
   logic       stop_high = 1'b0;
   logic       card_clk;

   int  n_chk = 0;
   int  n_err = 0;
   real last_edge = 0.0;
   real min_w = 1.0e9;
   bit  have_edge = 1'b0;
   bit  mon_on = 1'b0;

   always #2.5 clk_ref = ~clk_ref;

   card_clk_gen u_card_clk_gen (
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .rate_sel  (rate_sel),
      .stop_req  (stop_req),
      .stop_high (stop_high),
      .card_clk  (card_clk)
   );

   always @(card_clk) begin
      if (mon_on) begin
         if (have_edge && ($realtime - last_edge) < min_w) min_w = $realtime - last_edge;
         last_edge = $realtime;
         have_edge = 1'b1;
      end
   end

   function automatic real half_ns(input int code);
      return 2.5 * real'(1 << (3 - code));
   endfunction

   function automatic real rmin(input real a, input real b);
      return (a < b) ? a : b;
   endfunction

   task automatic chk(input bit ok, input string req, input real act, input real exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk_ref);
   endtask

   task automatic drive_at(input int off);
      @(posedge clk_ref);
      #(0.6 + 1.8 * off);
   endtask

   task automatic win_start();
      min_w = 1.0e9;
      have_edge = 1'b0;
      mon_on = 1'b1;
   endtask

   task automatic win_end(input real lim, input string req);
      mon_on = 1'b0;
      chk(min_w >= lim - 0.01, req, min_w, lim);
   endtask

   task automatic measure(input int code, input string req);
      real t0, t1, t2;
      @(posedge card_clk) t0 = $realtime;
      @(negedge card_clk) t1 = $realtime;
      @(posedge card_clk) t2 = $realtime;
      chk((t2 - t0) > 2.0 * half_ns(code) - 0.01 && (t2 - t0) < 2.0 * half_ns(code) + 0.01,
          {req, " period"}, t2 - t0, 2.0 * half_ns(code));
      chk((t1 - t0) > half_ns(code) - 0.01 && (t1 - t0) < half_ns(code) + 0.01,
          {req, " high time"}, t1 - t0, half_ns(code));
   endtask

   task automatic hold_level(input logic lvl, input string req);
      int bad;
      bad = 0;
      repeat (20) begin
         @(posedge clk_ref); #1.2;
         if (card_clk !== lvl) bad++;
         @(negedge clk_ref); #1.2;
         if (card_clk !== lvl) bad++;
      end
      chk(bad == 0, req, real'(bad), 0.0);
   endtask

   initial begin
      // R3: held low in reset even with pass-through selected
      rate_sel = 2'd3;
      stop_high = 1'b1;
      hold_level(1'b0, "R3 low during reset");
      rate_sel = 2'd0;
      stop_high = 1'b0;
      @(negedge clk_ref);
      rst_n = 1'b1;
      cyc(10);
      // R2: default rate is divide by 8
      measure(0, "R2 default rate");

      // R1: every code
      for (int s = 0; s < 4; s++) begin
         drive_at(0);
         rate_sel = 2'(s);
         cyc(30);
         measure(s, $sformatf("R1 code %0d", s));
      end

      // R8 / R9: every ordered pair of rates at two phases
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            if (a != b) begin
               for (int off = 0; off < 2; off++) begin
                  drive_at(0);
                  rate_sel = 2'(a);
                  cyc(30);
                  win_start();
                  drive_at(off);
                  rate_sel = 2'(b);
                  cyc(40);
                  win_end(rmin(half_ns(a), half_ns(b)),
                          $sformatf("%s min pulse %0d->%0d", (a == 3 || b == 3) ? "R9" : "R8", a, b));
                  measure(b, (a == 3 || b == 3) ? "R9 new rate" : "R8 new rate");
               end
            end
         end
      end

      // R4 / R5 / R6 / R7: stop and resume at every rate and both levels
      for (int s = 0; s < 4; s++) begin
         for (int p = 0; p < 2; p++) begin
            drive_at(0);
            rate_sel = 2'(s);
            cyc(30);
            win_start();
            drive_at(p);
            stop_high = 1'(p);
            stop_req = 1'b1;
            cyc(40);
            hold_level(1'(p), (p == 1) ? "R5 parked high" : "R4 parked low");
            win_end(half_ns(s), "R6 no partial pulse at stop");
            win_start();
            drive_at(1 - p);
            stop_req = 1'b0;
            cyc(40);
            win_end(half_ns(s), "R7 resume pulse width");
            measure(s, "R7 resumed rate");
         end
      end

      // R4 / R7: select change while parked low, then resume at new rate
      drive_at(0);
      rate_sel = 2'd0;
      stop_high = 1'b0;
      cyc(30);
      stop_req = 1'b1;
      cyc(40);
      rate_sel = 2'd2;
      hold_level(1'b0, "R4 select change while parked");
      stop_req = 1'b0;
      cyc(20);
      measure(2, "R7 new rate after low park");

      // R7 / R8: select change while parked high at divide by 4, then resume to divide by 8
      drive_at(0);
      rate_sel = 2'd1;
      cyc(30);
      stop_high = 1'b1;
      stop_req = 1'b1;
      cyc(40);
      rate_sel = 2'd0;
      cyc(10);
      win_start();
      stop_req = 1'b0;
      cyc(60);
      win_end(half_ns(1), "R7 high park resume min pulse");
      measure(0, "R8 rate after high park");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #500000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule